// File: doc/BRIEF.md
# Three-Level Priority Interrupt Controller

This block gathers one-cycle request pulses from a fixed group of peripheral sources and holds each in a request register bit. It then picks one pending request and presents it to a processor core as a request line and a source index. Each source has a two-bit priority field. A field of zero keeps the source out of arbitration, and the other three values select priority tiers 1 to 3, with tier 3 the most urgent. Within a tier, the lower source index wins. A parameter mask marks the sources that always compete at tier 3 once enabled, such as the watchdog timeout and the oscillator-failure detectors.

A master enable gates the request line. The processor's enable-interrupts, disable-interrupts, return-from-interrupt and acknowledge strobes change it, and so do writes through a small register port. An acknowledge clears the presented request bit and drops the master enable in the same edge. The presented index stays frozen while the request line is high and the presented source is still pending.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A one-cycle high on `src_i[k]` sets request bit k. The bit stays set over later cycles until something clears it.
- R2: A register write to address 0 clears every request bit whose write-data bit (bit k for source k) is 0. Write-data bits that are 1 leave their request bits unchanged.
- R3: An acknowledge, taken only while `irq_o` is high, clears the request bit of the presented index and clears the master enable. `irq_o` is low after that edge.
- R4: If a source pulse arrives in the same cycle as a clear of its bit (by acknowledge or by a software write of 0), the bit remains set.
- R5: The priority register (address 1) holds source k's field at bits [2k+1:2k]. Value 00 disables the source, and 01, 10 and 11 select tiers 1, 2 and 3. A disabled source still latches its request bit but never becomes the presented index.
- R6: A pending enabled request at a higher tier wins over any request at a lower tier, whatever the indices.
- R7: Among pending requests at the same tier, the lowest source index wins.
- R8: Sources in the FORCE_TOP mask (default sources 0, 1 and 2) compete at tier 3 whenever their field is non-zero.
- R9: The master enable (bit 0 at address 2) is set by the `ei_i` strobe, by the `iret_i` strobe, or by writing 1 to that bit.
- R10: The master enable is cleared by the `di_i` strobe and by writing 0 to that bit. When a clearing strobe and a setting strobe arrive together, the clear wins.
- R11: `irq_o` is high exactly when the master enable is set and an enabled request is pending. It changes on the same clock edge as the state that causes it.
- R12: While `irq_o` stays high and the presented source remains pending and enabled, `irq_idx_o` does not change, even if a higher-priority request arrives.
- R13: Reset clears all request bits, all priority fields, the master enable and both outputs. Reads return the state from before the clock edge one cycle later, and an unused address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | One-cycle request pulses, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 request, 1 priority, 2 control |
| reg_wdata_i | input | 2*NSRC | Register write data |
| reg_rdata_o | output | 2*NSRC | Registered read data |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| iret_i | input | 1 | Return-from-interrupt strobe |
| ack_i | input | 1 | Processor acknowledge of the presented request |
| irq_o | output | 1 | Request line to the processor |
| irq_idx_o | output | $clog2(NSRC) | Index of the presented source |

## Verification
The bench drives a pulse into the same cycle as an acknowledge or as a software clear of its own bit. A design that gave the clear priority would lose that event, and the request register would read back empty. It sets a low-index tier-1 source against a high-index tier-3 source, and a forced source with field 01 against an ordinary tier-3 source. A design that ranked by index alone, or ignored the force mask, would present the wrong index. It also raises a higher-priority request while another is being presented, and then clears the presented bit by software. A design that preempted too early, or never released the frozen index, would show the wrong index at one of those two points. Same-cycle enable and disable strobes catch a wrong resolution order on the master enable.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    ADDR_REQ = 2'd0,
    ADDR_LVL = 2'd1,
    ADDR_CTL = 2'd2
  } reg_addr_e;

  localparam logic [1:0] TIER_OFF = 2'b00;
  localparam logic [1:0] TIER_TOP = 2'b11;
endpackage

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] sw_clr,
  input  logic [NSRC-1:0] ack_clr,
  output logic [NSRC-1:0] req_q,
  output logic [NSRC-1:0] req_d
);
  // new pulses are OR-ed in after the clears so that an arrival is never lost
  always_comb req_d = (req_q & ~(sw_clr | ack_clr)) | src;

  always_ff @(posedge clk) begin
    if (rst) req_q <= '0;
    else     req_q <= req_d;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC = 8,
  localparam int DW = 2 * NSRC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we_lvl,
  input  logic          we_ctl,
  input  logic [DW-1:0] wdata,
  input  logic          ctl_bit,
  input  logic          ei,
  input  logic          di,
  input  logic          iret,
  input  logic          ack_fire,
  output logic [DW-1:0] lvl_q,
  output logic [DW-1:0] lvl_d,
  output logic          en_q,
  output logic          en_d
);
  always_comb begin
    lvl_d = we_lvl ? wdata : lvl_q;
    en_d  = we_ctl ? ctl_bit : en_q;
    if (ei || iret)     en_d = 1'b1;
    if (di || ack_fire) en_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      en_q  <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
      en_q  <= en_d;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] FORCE_TOP = '0,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]   req,
  input  logic [2*NSRC-1:0] lvl,
  output logic [NSRC-1:0]   elig,
  output logic              valid,
  output logic [IDXW-1:0]   idx
);
  logic [NSRC-1:0] hit1, hit2, hit3, sel;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [1:0] fld, tier;
    assign fld  = lvl[2*k +: 2];
    if (FORCE_TOP[k]) begin : g_forced
      assign tier = (fld == TIER_OFF) ? TIER_OFF : TIER_TOP;
    end else begin : g_plain
      assign tier = fld;
    end
    assign elig[k] = req[k] && (tier != TIER_OFF);
    assign hit1[k] = req[k] && (tier == 2'b01);
    assign hit2[k] = req[k] && (tier == 2'b10);
    assign hit3[k] = req[k] && (tier == 2'b11);
  end

  always_comb begin
    if (|hit3)      sel = hit3;
    else if (|hit2) sel = hit2;
    else            sel = hit1;
    valid = |sel;
    idx   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (sel[i]) idx = IDXW'(i);
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_pkg::*;
#(
  parameter int NSRC = 8,
  parameter logic [NSRC-1:0] FORCE_TOP = 8'b0000_0111,
  localparam int DW = 2 * NSRC,
  localparam int IDXW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            reg_we_i,
  input  logic [1:0]      reg_addr_i,
  input  logic [DW-1:0]   reg_wdata_i,
  output logic [DW-1:0]   reg_rdata_o,
  input  logic            ei_i,
  input  logic            di_i,
  input  logic            iret_i,
  input  logic            ack_i,
  output logic            irq_o,
  output logic [IDXW-1:0] irq_idx_o
);
  logic            we_req, we_lvl, we_ctl, ack_fire;
  logic [NSRC-1:0] sw_clr, ack_clr, req_q, req_d, elig_d;
  logic [DW-1:0]   lvl_q, lvl_d;
  logic            en_q, en_d, win_valid, irq_d;
  logic [IDXW-1:0] win_idx, idx_d;

  assign we_req   = reg_we_i && (reg_addr_i == ADDR_REQ);
  assign we_lvl   = reg_we_i && (reg_addr_i == ADDR_LVL);
  assign we_ctl   = reg_we_i && (reg_addr_i == ADDR_CTL);
  assign ack_fire = ack_i && irq_o;
  assign sw_clr   = we_req ? ~reg_wdata_i[NSRC-1:0] : '0;

  always_comb begin
    ack_clr = '0;
    if (ack_fire) ack_clr[irq_idx_o] = 1'b1;
  end

  irq_req_bank #(.NSRC(NSRC)) u_req (
    .clk(clk), .rst(rst), .src(src_i), .sw_clr(sw_clr), .ack_clr(ack_clr),
    .req_q(req_q), .req_d(req_d)
  );

  irq_cfg_regs #(.NSRC(NSRC)) u_cfg (
    .clk(clk), .rst(rst), .we_lvl(we_lvl), .we_ctl(we_ctl),
    .wdata(reg_wdata_i), .ctl_bit(reg_wdata_i[0]),
    .ei(ei_i), .di(di_i), .iret(iret_i), .ack_fire(ack_fire),
    .lvl_q(lvl_q), .lvl_d(lvl_d), .en_q(en_q), .en_d(en_d)
  );

  // arbitration runs on next-state values so outputs move with the state
  irq_arbiter #(.NSRC(NSRC), .FORCE_TOP(FORCE_TOP)) u_arb (
    .req(req_d), .lvl(lvl_d), .elig(elig_d), .valid(win_valid), .idx(win_idx)
  );

  assign irq_d = en_d && win_valid;
  assign idx_d = (irq_o && irq_d && elig_d[irq_idx_o]) ? irq_idx_o : win_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      irq_idx_o   <= '0;
      reg_rdata_o <= '0;
    end else begin
      irq_o     <= irq_d;
      irq_idx_o <= idx_d;
      case (reg_addr_i)
        ADDR_REQ: reg_rdata_o <= DW'(req_q);
        ADDR_LVL: reg_rdata_o <= lvl_q;
        ADDR_CTL: reg_rdata_o <= DW'(en_q);
        default:  reg_rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int NSRC = 8,
  localparam int IDXW = $clog2(NSRC)
) (
  input logic              clk,
  input logic              rst,
  input logic [NSRC-1:0]   src_i,
  input logic              ei_i,
  input logic              di_i,
  input logic              iret_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [IDXW-1:0]   irq_idx_o,
  input logic [NSRC-1:0]   req_q,
  input logic [2*NSRC-1:0] lvl_q,
  input logic              en_q
);
  logic            prev_irq;
  logic [IDXW-1:0] prev_idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_irq <= 1'b0;
      prev_idx <= '0;
    end else begin
      prev_irq <= irq_o;
      prev_idx <= irq_idx_o;
    end
  end

  // R11
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> en_q);

  // R4
  pulse_not_lost_chk: assert property (@(posedge clk) disable iff (rst)
    (|src_i) |=> ((req_q & $past(src_i)) == $past(src_i)));

  // R3
  ack_drops_enable_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o) |=> (!en_q && !irq_o));

  // R10
  di_clears_enable_chk: assert property (@(posedge clk) disable iff (rst)
    di_i |=> !en_q);

  // R9
  ei_sets_enable_chk: assert property (@(posedge clk) disable iff (rst)
    ((ei_i || iret_i) && !di_i && !(ack_i && irq_o)) |=> en_q);

  // R12
  idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o && prev_irq && req_q[prev_idx] && (lvl_q[2*prev_idx +: 2] != 2'b00))
      |-> (irq_idx_o == prev_idx));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst(rst), .src_i(src_i), .ei_i(ei_i), .di_i(di_i),
  .iret_i(iret_i), .ack_i(ack_i), .irq_o(irq_o), .irq_idx_o(irq_idx_o),
  .req_q(req_q), .lvl_q(lvl_q), .en_q(en_q)
);

// File: tb/sim_irq_prio_ctrl.sv
module sim_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  src = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        ei = 1'b0, di = 1'b0, iret = 1'b0, ack = 1'b0;
  logic        irq;
  logic [2:0]  idx;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  irq_prio_ctrl u0 (
    .clk(clk), .rst(rst), .src_i(src), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .ei_i(ei), .di_i(di),
    .iret_i(iret), .ack_i(ack), .irq_o(irq), .irq_idx_o(idx)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  task automatic pulse(input logic [7:0] m);
    src = m;
    tick();
    src = '0;
  endtask

  task automatic strobe(input bit e, input bit d, input bit r, input bit a);
    ei = e; di = d; iret = r; ack = a;
    tick();
    ei = 0; di = 0; iret = 0; ack = 0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    do_reset();
    chk("R13 irq after reset", 16'(irq), 16'h0);
    chk("R13 idx after reset", 16'(idx), 16'h0);
    rd(2'd0, v); chk("R13 request reg", v, 16'h0);
    rd(2'd1, v); chk("R13 priority reg", v, 16'h0);
    rd(2'd2, v); chk("R13 control reg", v, 16'h0);
    rd(2'd3, v); chk("R13 unused address", v, 16'h0);
  endtask

  task automatic t_latch();
    logic [15:0] v;
    do_reset();
    pulse(8'h10);
    tick(); tick(); tick();
    rd(2'd0, v); chk("R1 bit held after pulse", v, 16'h0010);
  endtask

  task automatic t_swclr();
    logic [15:0] v;
    do_reset();
    pulse(8'h30);
    wr(2'd0, 16'hFFEF);
    rd(2'd0, v); chk("R2 write 0 clears only bit 4", v, 16'h0020);
  endtask

  task automatic t_ack();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'h0080);
    wr(2'd2, 16'h0001);
    pulse(8'h08);
    chk("R3 irq before ack", 16'(irq), 16'h1);
    chk("R3 idx before ack", 16'(idx), 16'h3);
    strobe(0, 0, 0, 1);
    chk("R3 irq after ack", 16'(irq), 16'h0);
    rd(2'd0, v); chk("R3 request cleared by ack", v, 16'h0);
    rd(2'd2, v); chk("R3 enable cleared by ack", v, 16'h0);
  endtask

  task automatic t_collide();
    logic [15:0] v;
    do_reset();
    pulse(8'h04);
    src = 8'h04; we = 1'b1; addr = 2'd0; wdata = 16'h0000;
    tick();
    src = '0; we = 1'b0;
    rd(2'd0, v); chk("R4 pulse beats software clear", v, 16'h0004);
    wr(2'd1, 16'h0010);
    wr(2'd2, 16'h0001);
    chk("R4 irq for source 2", 16'(idx), 16'h2);
    src = 8'h04; ack = 1'b1;
    tick();
    src = '0; ack = 1'b0;
    rd(2'd0, v); chk("R4 pulse beats acknowledge", v, 16'h0004);
    chk("R4 irq low after ack", 16'(irq), 16'h0);
  endtask

  task automatic t_disabled();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'h0004);
    wr(2'd2, 16'h0001);
    pulse(8'h01);
    chk("R5 field 00 source not presented", 16'(irq), 16'h0);
    rd(2'd0, v); chk("R5 field 00 source still latched", v, 16'h0001);
    pulse(8'h02);
    chk("R5 field 01 source presented", 16'(irq), 16'h1);
    chk("R5 field 01 source index", 16'(idx), 16'h1);
  endtask

  task automatic t_levels();
    do_reset();
    wr(2'd1, 16'h3040);
    pulse(8'h48);
    wr(2'd2, 16'h0001);
    chk("R6 tier 3 index 6 beats tier 1 index 3", 16'(idx), 16'h6);
  endtask

  task automatic t_order();
    do_reset();
    wr(2'd1, 16'h0880);
    pulse(8'h28);
    wr(2'd2, 16'h0001);
    chk("R7 same tier lower index first", 16'(idx), 16'h3);
    strobe(0, 0, 0, 1);
    strobe(1, 0, 0, 0);
    chk("R7 next in order after ack", 16'(idx), 16'h5);
    chk("R7 irq after re-enable", 16'(irq), 16'h1);
  endtask

  task automatic t_force();
    do_reset();
    wr(2'd1, 16'h3004);
    pulse(8'h42);
    wr(2'd2, 16'h0001);
    chk("R8 forced source 1 at tier 3", 16'(idx), 16'h1);
  endtask

  task automatic t_enable();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'h0100);
    pulse(8'h10);
    chk("R9 no irq while disabled", 16'(irq), 16'h0);
    strobe(1, 0, 0, 0);
    chk("R9 ei raises irq", 16'(irq), 16'h1);
    strobe(0, 1, 0, 0);
    strobe(0, 0, 1, 0);
    chk("R9 iret raises irq", 16'(irq), 16'h1);
    strobe(0, 1, 0, 0);
    wr(2'd2, 16'h0001);
    chk("R9 write 1 raises irq", 16'(irq), 16'h1);
    rd(2'd2, v); chk("R9 enable reads 1", v, 16'h0001);
  endtask

  task automatic t_disable();
    logic [15:0] v;
    do_reset();
    wr(2'd1, 16'h0100);
    pulse(8'h10);
    strobe(1, 0, 0, 0);
    strobe(0, 1, 0, 0);
    chk("R10 di drops irq", 16'(irq), 16'h0);
    strobe(1, 0, 0, 0);
    wr(2'd2, 16'h0000);
    chk("R10 write 0 drops irq", 16'(irq), 16'h0);
    strobe(1, 1, 0, 0);
    chk("R10 di beats ei", 16'(irq), 16'h0);
    rd(2'd2, v); chk("R10 enable reads 0", v, 16'h0);
  endtask

  task automatic t_irqgate();
    do_reset();
    wr(2'd2, 16'h0001);
    chk("R11 no pending no irq", 16'(irq), 16'h0);
    pulse(8'h04);
    chk("R11 disabled source no irq", 16'(irq), 16'h0);
    wr(2'd1, 16'h0020);
    chk("R11 irq on same edge as field write", 16'(irq), 16'h1);
    chk("R11 index 2", 16'(idx), 16'h2);
  endtask

  task automatic t_hold();
    do_reset();
    wr(2'd1, 16'h3400);
    wr(2'd2, 16'h0001);
    pulse(8'h20);
    chk("R12 presents source 5", 16'(idx), 16'h5);
    pulse(8'h40);
    chk("R12 index held against tier 3 arrival", 16'(idx), 16'h5);
    wr(2'd0, 16'hFFDF);
    chk("R12 irq still high after clear", 16'(irq), 16'h1);
    chk("R12 hold released after clear", 16'(idx), 16'h6);
  endtask

  initial begin
    tick();
    t_reset();
    t_latch();
    t_swclr();
    t_ack();
    t_collide();
    t_disabled();
    t_levels();
    t_order();
    t_force();
    t_enable();
    t_disable();
    t_irqgate();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule